// File: doc/BRIEF.md
# Two-Thread Register Rename Unit

This block sits in the rename stage of a core that runs two hardware threads at once. Each thread has its own table that maps its logical registers to physical register tags. Both threads share a single pool of physical registers. Each cycle the unit takes at most one instruction. The instruction carries a thread selector, one destination logical register and two source logical registers. In the same cycle the unit returns the physical tags of both sources, read through that thread's own table. It also returns a fresh physical tag for the destination, taken from the head of a shared free list. At the next clock edge the selected thread's entry for the destination is changed to the fresh tag.

Freed tags come back through a release port at a rate of one per cycle. They join the tail of the free list, and tags are handed out in first-in first-out order. When the free list holds no tags, the ready output drops and the instruction stays where it is. Translation and allocation are combinational from the inputs and the stored state. Only the tables and the free list are registered.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, thread 0 maps logical register r to physical tag r, and thread 1 maps logical register r to physical tag r+8, for r from 0 to 7.
- R2: After reset the free list holds tags 16 to 63. The first destination tag offered on out_pdst is 16, and in_ready is 1.
- R3: Each accepted instruction (in_valid and in_ready both 1) receives the tag at the head of the free list on out_pdst. Successive acceptances receive successive free-list entries in order.
- R4: At the clock edge that accepts an instruction, the mapping of its thread for its destination becomes out_pdst. A later read of that logical register in the same thread returns the new tag.
- R5: Renaming in one thread leaves every mapping of the other thread unchanged.
- R6: A source equal to the destination of the same instruction reads the mapping held before that instruction's update.
- R7: When the free list is empty, in_ready is 0. An instruction presented then is not accepted: no mapping changes and no tag is consumed.
- R8: A tag presented with rel_valid is appended to the tail of the free list at that clock edge. It is handed out only after every tag that was already free.
- R9: A release and an accepted rename in the same cycle both take effect. With one free tag left, the next offered tag is the released one and in_ready stays 1. A release while empty raises in_ready in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_tid | input | 1 | Thread selector of the instruction |
| in_dst | input | 3 | Destination logical register |
| in_src1 | input | 3 | First source logical register |
| in_src2 | input | 3 | Second source logical register |
| in_ready | output | 1 | Free list is not empty, so an instruction can be accepted |
| out_psrc1 | output | 6 | Physical tag of the first source |
| out_psrc2 | output | 6 | Physical tag of the second source |
| out_pdst | output | 6 | Fresh physical tag for the destination |
| rel_valid | input | 1 | A freed tag is being returned this cycle |
| rel_tag | input | 6 | The tag being returned |

## Verification
Returning a freed tag and allocating a tag can happen in the same cycle. Both change the free list's count and its pointers at one edge. The bench first drains the pool down to empty. It then returns one tag, and in the next cycle renames while returning a second tag. The check is that in_ready stays high, that the newly returned tag is the next one offered, and that the rename after it uses that tag. A rename whose source equals its own destination also shares a cycle with the table update. That case is judged by checking that the old tag appears on the source output.

// File: rtl/rn_pkg.sv
package rn_pkg;
   localparam int RN_THREADS_DEF = 2;
   localparam int RN_LOG_DEF     = 8;
   localparam int RN_PHYS_DEF    = 64;

   // index width that stays at least one bit wide
   function automatic int idx_w(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
   parameter int NUM_LOG = 8,
   parameter int TAG_W   = 6,
   parameter int BASE    = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [rn_pkg::idx_w(NUM_LOG)-1:0] rd_idx1,
   input  logic [rn_pkg::idx_w(NUM_LOG)-1:0] rd_idx2,
   output logic [TAG_W-1:0]                  rd_tag1,
   output logic [TAG_W-1:0]                  rd_tag2,
   input  logic                              wr_en,
   input  logic [rn_pkg::idx_w(NUM_LOG)-1:0] wr_idx,
   input  logic [TAG_W-1:0]                  wr_tag
);
   logic [TAG_W-1:0] map_q [NUM_LOG];

   // reads see the pre-update contents (source equal to destination gets the old tag)
   assign rd_tag1 = map_q[rd_idx1];
   assign rd_tag2 = map_q[rd_idx2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LOG; i++)
            map_q[i] <= TAG_W'(BASE + i);
      end else if (wr_en) begin
         map_q[wr_idx] <= wr_tag;
      end
   end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
   parameter int NUM_PHYS  = 64,
   parameter int INIT_BASE = 16,
   parameter int INIT_CNT  = 48
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               pop,
   output logic [rn_pkg::idx_w(NUM_PHYS)-1:0] head_tag,
   output logic                               empty,
   input  logic                               push,
   input  logic [rn_pkg::idx_w(NUM_PHYS)-1:0] push_tag
);
   localparam int TAG_W = rn_pkg::idx_w(NUM_PHYS);
   localparam int CNT_W = $clog2(NUM_PHYS + 1);

   logic [TAG_W-1:0] mem [NUM_PHYS];
   logic [TAG_W-1:0] rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [CNT_W-1:0] count;

   generate
      if (rn_pkg::is_pow2(NUM_PHYS)) begin : g_wrap_free
         assign rd_nxt = rd_ptr + 1'b1;
         assign wr_nxt = wr_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign rd_nxt = (rd_ptr == TAG_W'(NUM_PHYS - 1)) ? '0 : rd_ptr + 1'b1;
         assign wr_nxt = (wr_ptr == TAG_W'(NUM_PHYS - 1)) ? '0 : wr_ptr + 1'b1;
      end
   endgenerate

   assign head_tag = mem[rd_ptr];
   assign empty    = (count == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++)
            mem[i] <= (i < INIT_CNT) ? TAG_W'(INIT_BASE + i) : '0;
         rd_ptr <= '0;
         wr_ptr <= TAG_W'(INIT_CNT % NUM_PHYS);
         count  <= CNT_W'(INIT_CNT);
      end else begin
         if (push) begin
            mem[wr_ptr] <= push_tag;
            wr_ptr      <= wr_nxt;
         end
         if (pop)
            rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R8: a release never arrives with every tag already free
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CNT_W'(NUM_PHYS)));
   // R7: nothing is taken from an empty list
   p_empty_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0) |-> !pop);
   // R3: an allocation without a release shrinks the pool by one
   p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (count == CNT_W'($past(count) - 1'b1)));
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
   parameter int NUM_THREADS = rn_pkg::RN_THREADS_DEF,
   parameter int NUM_LOG     = rn_pkg::RN_LOG_DEF,
   parameter int NUM_PHYS    = rn_pkg::RN_PHYS_DEF
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  in_valid,
   input  logic [rn_pkg::idx_w(NUM_THREADS)-1:0] in_tid,
   input  logic [rn_pkg::idx_w(NUM_LOG)-1:0]     in_dst,
   input  logic [rn_pkg::idx_w(NUM_LOG)-1:0]     in_src1,
   input  logic [rn_pkg::idx_w(NUM_LOG)-1:0]     in_src2,
   output logic                                  in_ready,
   output logic [rn_pkg::idx_w(NUM_PHYS)-1:0]    out_psrc1,
   output logic [rn_pkg::idx_w(NUM_PHYS)-1:0]    out_psrc2,
   output logic [rn_pkg::idx_w(NUM_PHYS)-1:0]    out_pdst,
   input  logic                                  rel_valid,
   input  logic [rn_pkg::idx_w(NUM_PHYS)-1:0]    rel_tag
);
   localparam int TAG_W     = rn_pkg::idx_w(NUM_PHYS);
   localparam int LIVE      = NUM_THREADS * NUM_LOG;
   localparam int INIT_FREE = NUM_PHYS - LIVE;

   generate
      if (INIT_FREE < 1) begin : g_bad_pool
         $error("physical pool must exceed the sum of all logical registers");
      end
      if (NUM_THREADS < 1 || NUM_LOG < 2) begin : g_bad_shape
         $error("need at least one thread and two logical registers");
      end
   endgenerate

   logic             fl_empty, fire;
   logic [TAG_W-1:0] fl_head;
   logic [TAG_W-1:0] t_rd1 [NUM_THREADS];
   logic [TAG_W-1:0] t_rd2 [NUM_THREADS];

   assign in_ready = !fl_empty;
   assign fire     = in_valid && in_ready;

   rn_free_list #(
      .NUM_PHYS  (NUM_PHYS),
      .INIT_BASE (LIVE),
      .INIT_CNT  (INIT_FREE)
   ) u_free (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop      (fire),
      .head_tag (fl_head),
      .empty    (fl_empty),
      .push     (rel_valid),
      .push_tag (rel_tag)
   );

   // one private table per thread; only the selected one is written
   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      rn_map_table #(
         .NUM_LOG (NUM_LOG),
         .TAG_W   (TAG_W),
         .BASE    (t * NUM_LOG)
      ) u_map (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_idx1 (in_src1),
         .rd_idx2 (in_src2),
         .rd_tag1 (t_rd1[t]),
         .rd_tag2 (t_rd2[t]),
         .wr_en   (fire && (int'(in_tid) == t)),
         .wr_idx  (in_dst),
         .wr_tag  (fl_head)
      );
   end

   assign out_psrc1 = t_rd1[in_tid];
   assign out_psrc2 = t_rd2[in_tid];
   assign out_pdst  = fl_head;

   // R3: a fresh tag is never one of the live source mappings
   p_fresh_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> (out_pdst != out_psrc1) && (out_pdst != out_psrc2));
   // R9: release plus rename leaves at least one tag available
   p_same_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && fire) |=> in_ready);
endmodule

// File: tb/tb_rn_rename_unit.sv
module tb_rn_rename_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [0:0] in_tid = '0;
   logic [2:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic       in_ready;
   logic [5:0] out_psrc1, out_psrc2, out_pdst;
   logic       rel_valid = 1'b0;
   logic [5:0] rel_tag = '0;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;

   always #5 clk = ~clk;

   rn_rename_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tid(in_tid),
      .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
      .in_ready(in_ready), .out_psrc1(out_psrc1), .out_psrc2(out_psrc2),
      .out_pdst(out_pdst), .rel_valid(rel_valid), .rel_tag(rel_tag)
   );

   // {tid, dst, src1, src2, exp_psrc1, exp_psrc2, exp_pdst}
   localparam logic [27:0] VEC [8] = '{
      {1'b0, 3'd1, 3'd1, 3'd2, 6'd1,  6'd2,  6'd16},  // R6 src==dst reads old
      {1'b1, 3'd1, 3'd1, 3'd0, 6'd9,  6'd8,  6'd17},  // R5 thread 1 untouched
      {1'b0, 3'd2, 3'd1, 3'd1, 6'd16, 6'd16, 6'd18},  // R4 newer tag
      {1'b1, 3'd0, 3'd1, 3'd2, 6'd17, 6'd10, 6'd19},
      {1'b0, 3'd7, 3'd2, 3'd0, 6'd18, 6'd0,  6'd20},
      {1'b1, 3'd7, 3'd7, 3'd0, 6'd15, 6'd19, 6'd21},
      {1'b0, 3'd1, 3'd7, 3'd1, 6'd20, 6'd16, 6'd22},
      {1'b1, 3'd3, 3'd1, 3'd7, 6'd17, 6'd21, 6'd23}   // R3 FIFO order
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_rn(input int tid, input int dst, input int s1, input int s2,
                        input int e1, input int e2, input int ed, input string req);
      @(negedge clk);
      in_tid = 1'(tid); in_dst = 3'(dst); in_src1 = 3'(s1); in_src2 = 3'(s2);
      in_valid = 1'b1;
      #1;
      chk(in_ready == 1'b1, req, in_ready, 1);
      chk(out_psrc1 == 6'(e1), req, out_psrc1, e1);
      chk(out_psrc2 == 6'(e2), req, out_psrc2, e2);
      chk(out_pdst == 6'(ed), req, out_pdst, ed);
      @(posedge clk);
      #1 in_valid = 1'b0;
   endtask

   task automatic do_rel(input int tag);
      @(negedge clk);
      rel_tag = 6'(tag); rel_valid = 1'b1;
      @(posedge clk);
      #1 rel_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 / R2: reset state read through the normal lookup path
      for (int t = 0; t < 2; t++) begin
         for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            in_tid = 1'(t); in_src1 = 3'(r); in_src2 = 3'(7 - r);
            #1;
            chk(out_psrc1 == 6'(r + 8 * t), "R1", out_psrc1, r + 8 * t);
            chk(out_psrc2 == 6'(7 - r + 8 * t), "R1", out_psrc2, 7 - r + 8 * t);
         end
      end
      chk(out_pdst == 6'd16, "R2", out_pdst, 16);
      chk(in_ready == 1'b1, "R2", in_ready, 1);

      // table walk: R3 R4 R5 R6
      for (int i = 0; i < 8; i++) begin
         logic [27:0] v;
         v = VEC[i];
         do_rn(int'(v[27]), int'(v[26:24]), int'(v[23:21]), int'(v[20:18]),
               int'(v[17:12]), int'(v[11:6]), int'(v[5:0]), "R3/R4/R5/R6 table");
      end

      // drain remaining 40 tags: R3 order and R4 chaining
      for (int k = 0; k < 40; k++)
         do_rn(0, 4, 4, 0, (k == 0) ? 4 : 23 + k, 0, 24 + k, "R3 drain");

      // R7: empty pool blocks
      chk(in_ready == 1'b0, "R7", in_ready, 0);
      @(negedge clk);
      in_tid = 1'b0; in_dst = 3'd5; in_src1 = 3'd5; in_src2 = 3'd0; in_valid = 1'b1;
      #1 chk(in_ready == 1'b0, "R7", in_ready, 0);
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      in_src1 = 3'd5;
      #1 chk(out_psrc1 == 6'd5, "R7 mapping unchanged", out_psrc1, 5);

      // R9: release while empty raises ready; no tag was consumed by the stall
      do_rel(1);
      chk(in_ready == 1'b1, "R9", in_ready, 1);
      chk(out_pdst == 6'd1, "R7 no tag consumed", out_pdst, 1);

      // R9: release and rename together with one tag left
      @(negedge clk);
      in_tid = 1'b0; in_dst = 3'd6; in_src1 = 3'd6; in_src2 = 3'd6; in_valid = 1'b1;
      rel_tag = 6'd16; rel_valid = 1'b1;
      #1;
      chk(out_psrc1 == 6'd6, "R9 src", out_psrc1, 6);
      chk(out_pdst == 6'd1, "R9 dst", out_pdst, 1);
      @(posedge clk);
      #1 in_valid = 1'b0; rel_valid = 1'b0;
      chk(in_ready == 1'b1, "R9 ready kept", in_ready, 1);
      chk(out_pdst == 6'd16, "R9 released tag next", out_pdst, 16);
      do_rn(0, 6, 6, 0, 1, 0, 16, "R9/R4 follow-up");
      chk(in_ready == 1'b0, "R7 empty again", in_ready, 0);

      // R8: released tags come back in release order
      do_rel(2);
      do_rel(6);
      do_rn(1, 2, 2, 0, 10, 19, 2, "R8 first");
      do_rn(1, 2, 2, 0, 2, 19, 6, "R8 second");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule